// File: doc/BRIEF.md
# ECP Forward Channel Transmitter

This block is the host-side engine that sends queued bytes to a peripheral over the forward direction of a 1284 extended-capabilities parallel link. It reads from a show-ahead FIFO. Each FIFO entry carries a byte and a command/data flag. For each byte, the block runs the host-clock / peripheral-acknowledge handshake on the eight data lines.

The acknowledge-side qualifier line marks each cycle. It is held high for a data byte and low for a command byte. For command bytes, the top bit selects how the low seven bits are read: a run-length count or a channel address. A kind output reports which of these is on the cable. The block drives a link-active line while the port is enabled or a transfer is still in progress.

The FIFO head is popped only when a cycle completes. The bus side therefore sees completion only. The block never sees the cable timing. If the peripheral stalls, a programmable counter ends the wait. The block then pulses a timeout flag and returns to idle without popping.

Top module: `ecp_fwd_tx`

## Requirements
- R1: After reset, host_clk_o is 1, host_ack_o is 1, kind_o is 0, fifo_pop_o is 0, timeout_o is 0, and active_o is 0 while enable_i is 0.
- R2: If the block is idle, enable_i is 1, periph_ack_i is low, and fifo_valid_i is raised, then data_o carries fifo_data_i. host_clk_o falls exactly SETUP_CYCLES+1 clock cycles after the valid is first sampled.
- R3: host_ack_o is 1 during a data cycle (fifo_cmd_i = 0) and 0 during a command cycle (fifo_cmd_i = 1).
- R4: kind_o encodes the cycle type: 0 when idle, 1 for data, 2 for a command with bit 7 = 0 (run-length count in bits 6:0), and 3 for a command with bit 7 = 1 (channel address in bits 6:0).
- R5: host_clk_o stays low until periph_ack_i is seen high. It rises SYNC_STAGES+1 cycles after periph_ack_i rises.
- R6: fifo_pop_o pulses for exactly one cycle, SYNC_STAGES cycles after periph_ack_i falls with host_clk_o high. It never pulses before that point.
- R7: If periph_ack_i does not change for timeout_lim_i cycles while the block waits on it, timeout_o pulses once. The pulse comes exactly timeout_lim_i cycles after the wait begins. host_clk_o is then 1, the block is idle, and no pop occurs.
- R8: A timeout_lim_i of 0 disables the timeout: the block waits on the peripheral indefinitely.
- R9: While enable_i is 0, no transfer starts. active_o follows enable_i one cycle later and is also 1 while a transfer is in progress.
- R10: No transfer starts while periph_ack_i is high in idle. The start happens once it returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Port is in a 1284 transfer mode |
| timeout_lim_i | input | TO_W | Stall limit in cycles, 0 disables |
| fifo_valid_i | input | 1 | FIFO head valid |
| fifo_data_i | input | 8 | FIFO head byte |
| fifo_cmd_i | input | 1 | FIFO head is a command byte |
| fifo_pop_o | output | 1 | Pop FIFO head, cycle completed |
| host_clk_o | output | 1 | Forward strobe to peripheral |
| host_ack_o | output | 1 | Data (1) / command (0) qualifier |
| data_o | output | 8 | Cable data lines |
| periph_ack_i | input | 1 | Peripheral acknowledge, asynchronous |
| active_o | output | 1 | Link active indication |
| kind_o | output | 2 | Current cycle kind |
| timeout_o | output | 1 | One-cycle stall timeout pulse |

## Verification
The hardest situation to reach from the ports is a timeout in the release phase. The peripheral must acknowledge the strobe and then hold its acknowledge high without ever dropping it, so the block has already raised host_clk_o and is waiting only for the falling edge. The bench peripheral model is steered into this case: it raises periph_ack_i, waits until host_clk_o is seen high, and then holds the line. The bench counts the cycles to the timeout pulse and confirms that no pop appears. A disabled limit is exercised by holding the strobe phase for hundreds of cycles.

// File: rtl/ecp_fwd_pkg.sv
package ecp_fwd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_STROBE  = 2'd2,
    ST_RELEASE = 2'd3
  } tx_state_e;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_DATA = 2'd1,
    KIND_RLE  = 2'd2,
    KIND_CHAN = 2'd3
  } tx_kind_e;
endpackage

// File: rtl/ecp_ack_sync.sv
module ecp_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q[i] <= 1'b0;
      else if (i == 0) sr_q[i] <= d_i;
      else sr_q[i] <= sr_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/ecp_fwd_timer.sv
module ecp_fwd_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clear_i || !run_i) cnt_q <= '0;
    else if (cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign expire_o = run_i && (lim_i != '0) && (cnt_q == lim_i - CNT_W'(1));

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && lim_i != '0 && $stable(lim_i)) |-> (cnt_q < lim_i)) else $error("cnt"); // R7
  AST_ZERO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_i == '0) |-> !expire_o) else $error("zero lim"); // R8
endmodule

// File: rtl/ecp_fwd_fsm.sv
module ecp_fwd_fsm
  import ecp_fwd_pkg::*;
#(
  parameter int SETUP_CYCLES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      valid_i,
  input  logic [7:0] data_i,
  input  logic      cmd_i,
  input  logic      ack_i,
  input  logic      expire_i,
  output tx_state_e state_o,
  output logic      clear_o,
  output logic      pop_o,
  output logic      timeout_o,
  output logic [7:0] data_o,
  output logic      cmd_o
);
  localparam int SET_W = (SETUP_CYCLES < 2) ? 1 : $clog2(SETUP_CYCLES + 1);

  tx_state_e        state_q, state_d;
  logic [SET_W-1:0] scnt_q;
  logic [7:0]       data_q;
  logic             cmd_q, tmo_q, tmo_d;

  always_comb begin
    state_d = state_q;
    tmo_d   = 1'b0;
    unique case (state_q)
      ST_IDLE:    if (en_i && valid_i && !ack_i) state_d = ST_SETUP;
      ST_SETUP:   if (scnt_q == '0) state_d = ST_STROBE;
      ST_STROBE: begin
        if (ack_i) state_d = ST_RELEASE;
        else if (expire_i) begin
          state_d = ST_IDLE;
          tmo_d   = 1'b1;
        end
      end
      ST_RELEASE: begin
        if (!ack_i) state_d = ST_IDLE;
        else if (expire_i) begin
          state_d = ST_IDLE;
          tmo_d   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      scnt_q  <= '0;
      data_q  <= '0;
      cmd_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tmo_q   <= tmo_d;
      if (state_q == ST_IDLE && state_d == ST_SETUP) begin
        data_q <= data_i;
        cmd_q  <= cmd_i;
        scnt_q <= SET_W'(SETUP_CYCLES - 1);
      end else if (state_q == ST_SETUP && scnt_q != '0) begin
        scnt_q <= scnt_q - SET_W'(1);
      end
    end
  end

  assign state_o   = state_q;
  assign clear_o   = (state_d != state_q);
  assign pop_o     = (state_q == ST_RELEASE) && !ack_i;
  assign timeout_o = tmo_q;
  assign data_o    = data_q;
  assign cmd_o     = cmd_q;

  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && state_d == ST_SETUP) |-> (en_i && !ack_i)) else $error("start"); // R9
  AST_SETUP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETUP) |-> $stable(data_q) || $past(state_q) == ST_IDLE) else $error("setup"); // R2
endmodule

// File: rtl/ecp_fwd_tx.sv
module ecp_fwd_tx
  import ecp_fwd_pkg::*;
#(
  parameter int SETUP_CYCLES = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int TO_W         = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enable_i,
  input  logic [TO_W-1:0] timeout_lim_i,
  input  logic            fifo_valid_i,
  input  logic [7:0]      fifo_data_i,
  input  logic            fifo_cmd_i,
  output logic            fifo_pop_o,
  output logic            host_clk_o,
  output logic            host_ack_o,
  output logic [7:0]      data_o,
  input  logic            periph_ack_i,
  output logic            active_o,
  output logic [1:0]      kind_o,
  output logic            timeout_o
);
  tx_state_e  state;
  logic       ack_s, clear, expire, cmd_q, en_q, run;
  logic [7:0] byte_q;
  tx_kind_e   kind;

  ecp_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(periph_ack_i), .q_o(ack_s)
  );

  assign run = (state == ST_STROBE) || (state == ST_RELEASE);

  ecp_fwd_timer #(.CNT_W(TO_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .clear_i (clear),
    .lim_i   (timeout_lim_i),
    .expire_o(expire)
  );

  ecp_fwd_fsm #(.SETUP_CYCLES(SETUP_CYCLES)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (enable_i),
    .valid_i  (fifo_valid_i),
    .data_i   (fifo_data_i),
    .cmd_i    (fifo_cmd_i),
    .ack_i    (ack_s),
    .expire_i (expire),
    .state_o  (state),
    .clear_o  (clear),
    .pop_o    (fifo_pop_o),
    .timeout_o(timeout_o),
    .data_o   (byte_q),
    .cmd_o    (cmd_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else en_q <= enable_i;
  end

  always_comb begin
    if (state == ST_IDLE) kind = KIND_NONE;
    else if (!cmd_q) kind = KIND_DATA;
    else if (byte_q[7]) kind = KIND_CHAN;
    else kind = KIND_RLE;
  end

  assign host_clk_o = (state != ST_STROBE);
  assign host_ack_o = (state == ST_IDLE) ? 1'b1 : !cmd_q;
  assign data_o     = byte_q;
  assign kind_o     = kind;
  assign active_o   = en_q || (state != ST_IDLE);

  AST_SETUP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(host_clk_o) |-> ($stable(data_o) && $stable(host_ack_o))) else $error("setup"); // R2
  AST_DATA_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == 2'd1) |-> host_ack_o) else $error("qual"); // R3
  AST_RISE_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_clk_o) |-> ($past(ack_s) || timeout_o)) else $error("rise"); // R5
  AST_POP_CLK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> (host_clk_o && !timeout_o)) else $error("pop"); // R6
  AST_POP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |=> !fifo_pop_o) else $error("pop twice"); // R6
  AST_TMO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (host_clk_o && kind_o == 2'd0)) else $error("tmo"); // R7
endmodule

// File: tb/ecp_fwd_tx_tb.sv
module ecp_fwd_tx_tb_top;
  localparam int SETUP = 2;
  localparam int SYNC  = 2;
  localparam int TO_W  = 16;
  localparam int NVEC  = 7;
  // {cmd, byte, ack delay}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 8'h5A, 4'd0}, {1'b0, 8'hFF, 4'd3}, {1'b1, 8'h05, 4'd1},
    {1'b1, 8'h7F, 4'd2}, {1'b1, 8'h80, 4'd0}, {1'b1, 8'hC3, 4'd5},
    {1'b0, 8'h00, 4'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, valid = 1'b0, cmd = 1'b0, pack = 1'b0;
  logic [TO_W-1:0] lim = 16'd100;
  logic [7:0] din = '0;
  logic pop, hclk, hack, active, tmo;
  logic [7:0] dout;
  logic [1:0] kind;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  ecp_fwd_tx #(.SETUP_CYCLES(SETUP), .SYNC_STAGES(SYNC), .TO_W(TO_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .timeout_lim_i(lim),
    .fifo_valid_i(valid), .fifo_data_i(din), .fifo_cmd_i(cmd), .fifo_pop_o(pop),
    .host_clk_o(hclk), .host_ack_o(hack), .data_o(dout), .periph_ack_i(pack),
    .active_o(active), .kind_o(kind), .timeout_o(tmo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic int exp_kind(input logic c, input logic [7:0] b);
    if (!c) return 1;
    return b[7] ? 3 : 2;
  endfunction

  task automatic wait_fall(output int cyc);
    cyc = 0;
    while (hclk && cyc < 400) begin @(negedge clk); cyc++; end
  endtask

  task automatic finish_hs(output int rise_c, output int pop_c, output bit early);
    early = 1'b0;
    pack = 1'b1;
    rise_c = 0;
    while (!hclk && rise_c < 50) begin @(negedge clk); rise_c++; early |= pop; end
    pack = 1'b0;
    pop_c = 0;
    while (!pop && pop_c < 50) begin @(negedge clk); pop_c++; end
    valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    report();
  end

  initial begin
    int cyc, rc, pc, tc;
    bit early, seen_pop, seen_tmo;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(hclk == 1, "R1 host_clk", hclk, 1);
    chk(hack == 1, "R1 host_ack", hack, 1);
    chk(kind == 0, "R1 kind", kind, 0);
    chk(!pop && !tmo, "R1 pop/tmo", pop | tmo, 0);
    chk(active == 0, "R1 active", active, 0);
    enable = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(active == 1, "R9 active follows enable", active, 1);

    for (int i = 0; i < NVEC; i++) begin
      cmd = VEC[i][12]; din = VEC[i][11:4]; valid = 1'b1;
      wait_fall(cyc);
      chk(cyc == SETUP + 1, "R2 strobe latency", cyc, SETUP + 1);
      chk(dout == VEC[i][11:4], "R2 data", dout, VEC[i][11:4]);
      chk(hack == !VEC[i][12], "R3 host_ack", hack, !VEC[i][12]);
      chk(kind == exp_kind(VEC[i][12], VEC[i][11:4]), "R4 kind", kind,
          exp_kind(VEC[i][12], VEC[i][11:4]));
      repeat (VEC[i][3:0]) @(negedge clk);
      chk(hclk == 0 && !pop, "R5 hold low before ack", hclk, 0);
      finish_hs(rc, pc, early);
      chk(rc == SYNC + 1, "R5 rise latency", rc, SYNC + 1);
      chk(!early, "R6 no early pop", early, 0);
      chk(pc == SYNC, "R6 pop latency", pc, SYNC);
      chk(!pop, "R6 single pop", pop, 0);
      chk(kind == 0, "R4 idle kind", kind, 0);
    end

    // R7 timeout in strobe phase
    lim = 16'd10; cmd = 1'b0; din = 8'h33; valid = 1'b1;
    wait_fall(cyc);
    tc = 0; seen_pop = 0;
    while (!tmo && tc < 100) begin @(negedge clk); tc++; seen_pop |= pop; end
    valid = 1'b0;
    chk(tc == 10, "R7 strobe timeout cycles", tc, 10);
    chk(hclk == 1, "R7 clk released", hclk, 1);
    chk(!seen_pop, "R7 no pop", seen_pop, 0);
    @(negedge clk);
    chk(!tmo && kind == 0, "R7 single pulse idle", tmo, 0);

    // R7 timeout in release phase: ack held high
    valid = 1'b1; cmd = 1'b1; din = 8'h81;
    wait_fall(cyc);
    pack = 1'b1;
    while (!hclk) @(negedge clk);
    tc = 0; seen_pop = 0;
    while (!tmo && tc < 100) begin @(negedge clk); tc++; seen_pop |= pop; end
    valid = 1'b0;
    chk(tc == 10, "R7 release timeout cycles", tc, 10);
    chk(!seen_pop, "R7 no pop in release", seen_pop, 0);
    pack = 1'b0;
    repeat (5) @(negedge clk);

    // R8 limit zero disables timeout
    lim = '0; valid = 1'b1; cmd = 1'b0; din = 8'hA5;
    wait_fall(cyc);
    seen_tmo = 0;
    for (int k = 0; k < 300; k++) begin @(negedge clk); seen_tmo |= tmo | hclk; end
    chk(!seen_tmo, "R8 no timeout with zero limit", seen_tmo, 0);
    finish_hs(rc, pc, early);
    chk(pc == SYNC, "R8 completes later", pc, SYNC);
    lim = 16'd100;

    // R10 no start while ack high in idle
    pack = 1'b1;
    repeat (4) @(negedge clk);
    valid = 1'b1; din = 8'h11;
    seen_tmo = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); seen_tmo |= !hclk; end
    chk(!seen_tmo && kind == 0, "R10 held off by ack", seen_tmo, 0);
    pack = 1'b0;
    wait_fall(cyc);
    chk(cyc == SYNC + SETUP + 1, "R10 start after ack low", cyc, SYNC + SETUP + 1);
    finish_hs(rc, pc, early);

    // R9 enable low blocks start
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(active == 0, "R9 active drops", active, 0);
    valid = 1'b1; din = 8'h22;
    seen_tmo = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); seen_tmo |= !hclk | pop; end
    chk(!seen_tmo && kind == 0, "R9 no transfer while disabled", seen_tmo, 0);
    enable = 1'b1;
    wait_fall(cyc);
    chk(dout == 8'h22 && active == 1, "R9 start once enabled", dout, 8'h22);
    finish_hs(rc, pc, early);
    chk(pc == SYNC, "R9 completes", pc, SYNC);

    report();
  end
endmodule